// File: doc/BRIEF.md
# Single-Bit Manipulation Unit

This combinational unit carries out the single-bit group of integer operations for a processor core whose register width (XLEN) is 32 or 64 bits. Each cycle it takes an operation code, a source operand and a bit position. It returns the source with one bit set, cleared or flipped, or it returns that one bit on its own, zero-extended to the full width.

The bit position can come from the second register operand or from the immediate field of the instruction. A select input picks between them. Both forms share one datapath: the selected position is reduced modulo XLEN, turned into a one-hot mask, and fed to the combining rule that the operation code names.

An enable input, driven by the extension's configuration, qualifies the result. There are no states; the operation code plays the role of a mode selector. The four modes are set, clear, invert and extract.

Top module: `bitmanip_single_unit`

## Requirements
- R1: Operation code 2'b00 (set) gives a result equal to the source with bit p forced to 1, where p is the selected position taken modulo XLEN. All other bits are unchanged.
- R2: Operation code 2'b01 (clear) gives the source with bit p forced to 0. All other bits are unchanged.
- R3: Operation code 2'b10 (invert) gives the source with bit p flipped. All other bits are unchanged.
- R4: Operation code 2'b11 (extract) gives a result whose bit 0 equals source bit p and whose higher bits are all zero.
- R5: When the register form is selected, only the low log2(XLEN) bits of the register position operand count (5 bits for XLEN 32, 6 for XLEN 64). Any higher bits have no effect on the result.
- R6: When the immediate select is 1, the position comes from the 6-bit immediate input, reduced modulo XLEN. The register position operand is then ignored. When the select is 0, the immediate input is ignored. For equal positions both forms give identical results.
- R7: The valid output equals the enable input. While the enable is 0 the result output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| en_i | input | 1 | Extension enable; qualifies the result |
| op_i | input | 2 | Operation: 00 set, 01 clear, 10 invert, 11 extract |
| src_i | input | XLEN | Source operand |
| use_imm_i | input | 1 | 1 selects the immediate position, 0 the register position |
| reg_pos_i | input | XLEN | Position from the register operand |
| imm_pos_i | input | 6 | Position from the immediate field |
| res_o | output | XLEN | Result |
| valid_o | output | 1 | Result valid |

## Verification
The bench sweeps every position from 0 to 2*XLEN-1 for each operation in both forms. A design that used one position bit too many would return unchanged data or zero for the upper half of that range. A design that dropped the top position bit would hit the wrong bit. Extract is checked against sources with every bit set, which catches a design that leaves the shifted source unmasked and returns nonzero upper bits. The bench also puts conflicting values on the unselected position input; a wrong select sense then shows up as a change on the wrong bit.

// File: rtl/bitmanip_pkg.sv
package bitmanip_pkg;
    typedef enum logic [1:0] {
        BOP_SET     = 2'b00,
        BOP_CLEAR   = 2'b01,
        BOP_INVERT  = 2'b10,
        BOP_EXTRACT = 2'b11
    } bop_e;
    localparam int IMM_POS_W = 6;
endpackage

// File: rtl/bitmanip_pos_mask.sv
module bitmanip_pos_mask #(
    parameter int XLEN  = 64,
    parameter int POS_W = $clog2(XLEN)
) (
    input  logic                                 use_imm_i,
    input  logic [XLEN-1:0]                      reg_pos_i,
    input  logic [bitmanip_pkg::IMM_POS_W-1:0]   imm_pos_i,
    output logic [POS_W-1:0]                     pos_o,
    output logic [XLEN-1:0]                      mask_o
);
    logic [POS_W-1:0] pos_sel;

    always_comb begin
        if (use_imm_i) pos_sel = imm_pos_i[POS_W-1:0];
        else           pos_sel = reg_pos_i[POS_W-1:0];
    end

    assign pos_o = pos_sel;

    for (genvar g = 0; g < XLEN; g++) begin : g_dec
        assign mask_o[g] = (pos_sel == POS_W'(g));
    end

    always_comb begin
        AST_MASK_ONEHOT: assert ($countones(mask_o) == 1); // R1
    end
endmodule

// File: rtl/bitmanip_combine.sv
module bitmanip_combine #(
    parameter int XLEN  = 64,
    parameter int POS_W = $clog2(XLEN)
) (
    input  bitmanip_pkg::bop_e   op_i,
    input  logic [XLEN-1:0]      src_i,
    input  logic [XLEN-1:0]      mask_i,
    input  logic [POS_W-1:0]     pos_i,
    output logic [XLEN-1:0]      res_o
);
    import bitmanip_pkg::*;

    logic [XLEN-1:0] shifted;
    assign shifted = src_i >> pos_i;

    always_comb begin
        unique case (op_i)
            BOP_SET:     res_o = src_i | mask_i;
            BOP_CLEAR:   res_o = src_i & ~mask_i;
            BOP_INVERT:  res_o = src_i ^ mask_i;
            BOP_EXTRACT: res_o = {{(XLEN-1){1'b0}}, shifted[0]};
            default:     res_o = '0;
        endcase
    end

    always_comb begin
        if (op_i == BOP_SET)
            AST_SET_HIT: assert ((res_o & mask_i) == mask_i); // R1
        if (op_i == BOP_CLEAR)
            AST_CLEAR_HIT: assert ((res_o & mask_i) == '0); // R2
        if (op_i == BOP_INVERT)
            AST_INVERT_ONE: assert ($countones(res_o ^ src_i) == 1); // R3
        if (op_i == BOP_EXTRACT)
            AST_EXTRACT_NARROW: assert (res_o[XLEN-1:1] == '0); // R4
    end
endmodule

// File: rtl/bitmanip_single_unit.sv
module bitmanip_single_unit #(
    parameter int XLEN = 64
) (
    input  logic                                en_i,
    input  logic [1:0]                          op_i,
    input  logic [XLEN-1:0]                     src_i,
    input  logic                                use_imm_i,
    input  logic [XLEN-1:0]                     reg_pos_i,
    input  logic [bitmanip_pkg::IMM_POS_W-1:0]  imm_pos_i,
    output logic [XLEN-1:0]                     res_o,
    output logic                                valid_o
);
    import bitmanip_pkg::*;
    localparam int POS_W = $clog2(XLEN);

    logic [POS_W-1:0] pos;
    logic [XLEN-1:0]  mask;
    logic [XLEN-1:0]  raw_res;
    bop_e             op;

    assign op = bop_e'(op_i);

    bitmanip_pos_mask #(.XLEN(XLEN), .POS_W(POS_W)) u_mask (
        .use_imm_i (use_imm_i),
        .reg_pos_i (reg_pos_i),
        .imm_pos_i (imm_pos_i),
        .pos_o     (pos),
        .mask_o    (mask)
    );

    bitmanip_combine #(.XLEN(XLEN), .POS_W(POS_W)) u_comb (
        .op_i   (op),
        .src_i  (src_i),
        .mask_i (mask),
        .pos_i  (pos),
        .res_o  (raw_res)
    );

    assign valid_o = en_i;
    assign res_o   = en_i ? raw_res : '0;

    always_comb begin
        if (!en_i)
            AST_IDLE_ZERO: assert (res_o == '0); // R7
    end
endmodule

// File: tb/bitmanip_single_unit_tb.sv
module bitmanip_single_unit_tb_top;
    localparam int XLEN = 64;
    localparam int CLK_PERIOD = 10;

    logic            clk = 0;
    logic            en;
    logic [1:0]      op;
    logic [XLEN-1:0] src;
    logic            use_imm;
    logic [XLEN-1:0] reg_pos;
    logic [5:0]      imm_pos;
    logic [XLEN-1:0] res;
    logic            valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bitmanip_single_unit #(.XLEN(XLEN)) dut_i (
        .en_i(en), .op_i(op), .src_i(src), .use_imm_i(use_imm),
        .reg_pos_i(reg_pos), .imm_pos_i(imm_pos), .res_o(res), .valid_o(valid)
    );

    function automatic logic [XLEN-1:0] ref_model(input logic e, input logic [1:0] o,
            input logic [XLEN-1:0] s, input logic ui, input logic [XLEN-1:0] rp,
            input logic [5:0] ip);
        int p;
        logic [XLEN-1:0] r;
        p = ui ? (int'(ip) % XLEN) : int'(rp % XLEN);
        r = s;
        case (o)
            2'b00: r[p] = 1'b1;
            2'b01: r[p] = 1'b0;
            2'b10: r[p] = ~s[p];
            default: begin r = '0; r[0] = s[p]; end
        endcase
        return e ? r : '0;
    endfunction

    task automatic apply_check(input logic e, input logic [1:0] o, input logic [XLEN-1:0] s,
            input logic ui, input logic [XLEN-1:0] rp, input logic [5:0] ip, input string tag);
        logic [XLEN-1:0] exp_v;
        @(posedge clk);
        en = e; op = o; src = s; use_imm = ui; reg_pos = rp; imm_pos = ip;
        exp_v = ref_model(e, o, s, ui, rp, ip);
        @(negedge clk);
        n_checks++;
        if (res !== exp_v || valid !== e) begin
            n_fail++;
            $display("FAIL %s op=%0d imm=%0b pos=%0h/%0h: res=%h valid=%b expected res=%h valid=%b",
                     tag, o, ui, rp, ip, res, valid, exp_v, e);
        end
    endtask

    function automatic string op_tag(input logic [1:0] o);
        case (o)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [XLEN-1:0] s;
        void'($urandom(32'd1234));
        en = 0; op = 0; src = '1; use_imm = 0; reg_pos = 0; imm_pos = 0;
        // R7: disabled gives zero and no valid
        apply_check(1'b0, 2'b00, '1, 1'b0, 3, 6'd0, "R7");
        apply_check(1'b0, 2'b11, '1, 1'b1, 0, 6'd5, "R7");
        // Sweep every position, both forms, upper bits set past XLEN (R5, R6)
        for (int o = 0; o < 4; o++) begin
            for (int p = 0; p < 2*XLEN; p++) begin
                s = {$urandom, $urandom};
                apply_check(1'b1, 2'(o), s, 1'b0, XLEN'(p), 6'(~p), {op_tag(2'(o)), " R5"});
                if (p < 64)
                    apply_check(1'b1, 2'(o), s, 1'b1, {$urandom, $urandom}, 6'(p),
                                {op_tag(2'(o)), " R6"});
            end
        end
        // R4: extract from all-ones and all-zeros sources
        apply_check(1'b1, 2'b11, '1, 1'b0, XLEN'(XLEN-1), 6'd0, "R4");
        apply_check(1'b1, 2'b11, '0, 1'b1, '1, 6'd63, "R4");
        // R1 R2 R3 boundaries
        apply_check(1'b1, 2'b00, '0, 1'b0, '1, 6'd0, "R1");
        apply_check(1'b1, 2'b01, '1, 1'b1, '0, 6'd63, "R2");
        apply_check(1'b1, 2'b10, '0, 1'b0, {1'b1, {(XLEN-1){1'b0}}}, 6'd1, "R3");
        // R5: huge register position
        apply_check(1'b1, 2'b10, '1, 1'b0, {{(XLEN-6){1'b1}}, 6'd7}, 6'd0, "R5");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0] ro;
            ro = 2'($urandom);
            apply_check(1'($urandom), ro, {$urandom, $urandom}, 1'($urandom),
                        {$urandom, $urandom}, 6'($urandom), {op_tag(ro), " R6 R7"});
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule